// File: doc/BRIEF.md
# Prioritized Interrupt Entry Unit

This block decides, one cycle at a time, whether a requested interrupt level may preempt the processor, and if it may, it produces every state change that entering the handler implies. The change set covers the redirected program counter, the rewritten status word, writes to the banked saved-PC and saved-status registers and to the double-exception PC register, a cause code and an exception class. The register file and the fetch logic take these strobes and values and apply them. They come out together, one clock after the request is seen.

Levels 2 and above are high-priority. They bank the PC and the status word at their own index and jump straight to a per-level vector. When vector relocation is built in, that vector is moved from its default base to the live vector base register. Level 1 is different. It is turned into a general exception: user, kernel or double, chosen from the exception-mode and user-mode bits of the status word. The PC stays where it is for a later dispatch stage to redirect.

Top module: `irq_entry_unit`

## Requirements
- R1: A request is taken only if `req_valid` is high, `req_level` is nonzero, is strictly above the current level held in `status[3:0]`, is at most `NLEVEL`, and the AND of that level's mask (slice `level_mask[(L-1)*NIRQ +: NIRQ]`), `intset` and `intenable` is nonzero.
- R2: On a taken level L above 1, the saved-PC write targets index L with `cur_pc`, and the saved-status write targets index L with the old `status`. No cause is written and `exc_class_o` is 0.
- R3: On a taken level L above 1, `new_status_o` keeps bits above 4 of `status`, sets bit 4 (exception mode) and holds L in bits 3:0.
- R4: On a taken level L above 1, `new_pc_o` is entry L-1 of `vec_table`. With `RELOC=1` it is that entry minus `DEF_VECBASE` plus `vecbase`, modulo 2^XLEN.
- R5: On a taken level-1 request, `cause_we_o` pulses with `cause_o` = 4, and no saved-status write occurs.
- R6: On a taken level-1 request with `status[4]` set, `exc_class_o` is 3 (double). The PC goes to `depc_data_o` with `depc_we_o` when `HAS_DEPC=1`, and otherwise to saved-PC index 1.
- R7: On a taken level-1 request with `status[4]` clear, the PC goes to saved-PC index 1. `exc_class_o` is 2 (user) when `status[UM_BIT]` (bit 5 by default) is set, and 1 (kernel) otherwise.
- R8: On a taken level-1 request, `new_status_o` equals `status` with bit 4 set, and `new_pc_o` equals `cur_pc`.
- R9: All outputs of a taken request appear together one clock after it is sampled. A cycle with no take raises no strobe, drives `exc_class_o` to 0 and leaves every data output unchanged.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A pending interrupt level is presented |
| req_level | input | 4 | Pending interrupt level |
| status | input | XLEN | Current status word; bits 3:0 current level, bit 4 exception mode, bit UM_BIT user mode |
| intset | input | NIRQ | Raised interrupt lines |
| intenable | input | NIRQ | Enabled interrupt lines |
| level_mask | input | NLEVEL*NIRQ | Per-level line masks, level L at slice L-1 |
| cur_pc | input | XLEN | PC of the interrupted instruction |
| vecbase | input | XLEN | Live vector base register |
| vec_table | input | NLEVEL*XLEN | Default per-level vectors, level L at slice L-1 |
| taken_o | output | 1 | Entry performed this cycle |
| new_pc_o | output | XLEN | PC after entry |
| new_status_o | output | XLEN | Status word after entry |
| epc_we_o | output | 1 | Saved-PC write strobe |
| epc_idx_o | output | 4 | Saved-PC index |
| epc_data_o | output | XLEN | Saved-PC value |
| eps_we_o | output | 1 | Saved-status write strobe |
| eps_idx_o | output | 4 | Saved-status index |
| eps_data_o | output | XLEN | Saved-status value |
| depc_we_o | output | 1 | Double-exception PC write strobe |
| depc_data_o | output | XLEN | Double-exception PC value |
| cause_we_o | output | 1 | Cause register write strobe |
| cause_o | output | 6 | Cause code |
| exc_class_o | output | 2 | 0 none, 1 kernel, 2 user, 3 double |

## Verification
The bench builds two copies side by side from the same stimulus. One has six levels, a double-exception PC register and relocation enabled. The other has six levels, no double-exception PC register and fixed vectors. Together they reach both routes a double exception can take to store its PC, and both ways of forming a vector. Requests at level 7 check the upper bound on levels. Requests at the current level check the strictly-greater rule, and all-zero masks check the line-enable AND.

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter int              NLEVEL      = 6,
  parameter int              NIRQ        = 32,
  parameter int              XLEN        = 32,
  parameter int              UM_BIT      = 5,
  parameter bit              HAS_DEPC    = 1'b1,
  parameter bit              RELOC       = 1'b1,
  parameter logic [XLEN-1:0] DEF_VECBASE = XLEN'(32'h4000_0000)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [3:0]             req_level,
  input  logic [XLEN-1:0]        status,
  input  logic [NIRQ-1:0]        intset,
  input  logic [NIRQ-1:0]        intenable,
  input  logic [NLEVEL*NIRQ-1:0] level_mask,
  input  logic [XLEN-1:0]        cur_pc,
  input  logic [XLEN-1:0]        vecbase,
  input  logic [NLEVEL*XLEN-1:0] vec_table,
  output logic                   taken_o,
  output logic [XLEN-1:0]        new_pc_o,
  output logic [XLEN-1:0]        new_status_o,
  output logic                   epc_we_o,
  output logic [3:0]             epc_idx_o,
  output logic [XLEN-1:0]        epc_data_o,
  output logic                   eps_we_o,
  output logic [3:0]             eps_idx_o,
  output logic [XLEN-1:0]        eps_data_o,
  output logic                   depc_we_o,
  output logic [XLEN-1:0]        depc_data_o,
  output logic                   cause_we_o,
  output logic [5:0]             cause_o,
  output logic [1:0]             exc_class_o
);

  localparam logic [3:0]      MAX_LVL  = 4'(NLEVEL);
  localparam logic [5:0]      CAUSE_L1 = 6'd4;
  localparam logic [1:0]      CLS_KERN = 2'd1;
  localparam logic [1:0]      CLS_USER = 2'd2;
  localparam logic [1:0]      CLS_DBL  = 2'd3;
  localparam logic [XLEN-1:0] EXCM     = XLEN'(1) << 4;

  logic [NIRQ-1:0] sel_mask;
  logic [XLEN-1:0] sel_vec;
  logic [XLEN-1:0] vec_eff;
  logic            hit;
  logic            is_hi;

  always_comb begin
    sel_mask = '0;
    sel_vec  = '0;
    for (int i = 1; i <= NLEVEL; i++) begin
      if (req_level == 4'(i)) begin
        sel_mask = level_mask[(i-1)*NIRQ +: NIRQ];
        sel_vec  = vec_table[(i-1)*XLEN +: XLEN];
      end
    end
  end

  generate
    if (RELOC) begin : g_reloc
      assign vec_eff = sel_vec - DEF_VECBASE + vecbase;
    end else begin : g_fixed
      assign vec_eff = sel_vec;
    end
  endgenerate

  assign hit = req_valid && (req_level != 4'd0) && (req_level <= MAX_LVL)
            && (req_level > status[3:0]) && |(sel_mask & intset & intenable);
  assign is_hi = req_level > 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o      <= 1'b0;
      new_pc_o     <= '0;
      new_status_o <= '0;
      epc_we_o     <= 1'b0;
      epc_idx_o    <= '0;
      epc_data_o   <= '0;
      eps_we_o     <= 1'b0;
      eps_idx_o    <= '0;
      eps_data_o   <= '0;
      depc_we_o    <= 1'b0;
      depc_data_o  <= '0;
      cause_we_o   <= 1'b0;
      cause_o      <= '0;
      exc_class_o  <= '0;
    end else begin
      taken_o     <= hit;
      epc_we_o    <= 1'b0;
      eps_we_o    <= 1'b0;
      depc_we_o   <= 1'b0;
      cause_we_o  <= 1'b0;
      exc_class_o <= '0;
      if (hit) begin
        if (is_hi) begin
          new_pc_o     <= vec_eff;
          new_status_o <= {status[XLEN-1:5], 1'b1, req_level};
          epc_we_o     <= 1'b1;
          epc_idx_o    <= req_level;
          epc_data_o   <= cur_pc;
          eps_we_o     <= 1'b1;
          eps_idx_o    <= req_level;
          eps_data_o   <= status;
        end else begin
          new_pc_o     <= cur_pc;
          new_status_o <= status | EXCM;
          cause_we_o   <= 1'b1;
          cause_o      <= CAUSE_L1;
          if (status[4]) begin
            exc_class_o <= CLS_DBL;
            if (HAS_DEPC) begin
              depc_we_o   <= 1'b1;
              depc_data_o <= cur_pc;
            end else begin
              epc_we_o   <= 1'b1;
              epc_idx_o  <= 4'd1;
              epc_data_o <= cur_pc;
            end
          end else begin
            exc_class_o <= status[UM_BIT] ? CLS_USER : CLS_KERN;
            epc_we_o    <= 1'b1;
            epc_idx_o   <= 4'd1;
            epc_data_o  <= cur_pc;
          end
        end
      end
    end
  end

endmodule

// File: rtl/irq_entry_unit_chk.sv
module irq_entry_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [3:0]      req_level,
  input logic [XLEN-1:0] status,
  input logic            taken_o,
  input logic [XLEN-1:0] new_pc_o,
  input logic [XLEN-1:0] new_status_o,
  input logic            epc_we_o,
  input logic            eps_we_o,
  input logic [3:0]      eps_idx_o,
  input logic            depc_we_o,
  input logic            cause_we_o,
  input logic [5:0]      cause_o,
  input logic [1:0]      exc_class_o
);

  // R1
  take_needs_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ($past(req_valid) && ($past(req_level) > $past(status[3:0]))));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> (!epc_we_o && !eps_we_o && !depc_we_o && !cause_we_o && exc_class_o == 2'd0));

  // R9
  idle_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> $stable(new_pc_o));

  // R6
  one_pc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ($countones({epc_we_o, depc_we_o}) == 1));

  // R5
  l1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && exc_class_o != 2'd0) |-> (cause_we_o && cause_o == 6'd4 && !eps_we_o));

  // R3
  hi_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && eps_we_o) |-> (new_status_o[4] && new_status_o[3:0] == eps_idx_o && exc_class_o == 2'd0));

  // R8
  excm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> new_status_o[4]);

endmodule

bind irq_entry_unit irq_entry_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_irq_entry_unit.sv
module tb_irq_entry_unit;

  localparam int NL = 6;
  localparam int NI = 32;
  localparam int XL = 32;
  localparam logic [31:0] DVB = 32'h4000_0000;

  typedef struct packed {
    logic        taken;
    logic [31:0] new_pc;
    logic [31:0] new_status;
    logic        epc_we;
    logic [3:0]  epc_idx;
    logic [31:0] epc_data;
    logic        eps_we;
    logic [3:0]  eps_idx;
    logic [31:0] eps_data;
    logic        depc_we;
    logic [31:0] depc_data;
    logic        cause_we;
    logic [5:0]  cause;
    logic [1:0]  exc_class;
  } outs_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           req_valid = 1'b0;
  logic [3:0]     req_level = '0;
  logic [31:0]    status = '0;
  logic [NI-1:0]  intset = '0;
  logic [NI-1:0]  intenable = '0;
  logic [NL*NI-1:0] level_mask = '0;
  logic [31:0]    cur_pc = '0;
  logic [31:0]    vecbase = '0;
  logic [NL*XL-1:0] vec_table = '0;

  outs_t act_a, act_b, exp_a, exp_b;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  irq_entry_unit #(.NLEVEL(NL), .NIRQ(NI), .XLEN(XL), .HAS_DEPC(1'b1), .RELOC(1'b1), .DEF_VECBASE(DVB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level), .status(status),
    .intset(intset), .intenable(intenable), .level_mask(level_mask), .cur_pc(cur_pc),
    .vecbase(vecbase), .vec_table(vec_table),
    .taken_o(act_a.taken), .new_pc_o(act_a.new_pc), .new_status_o(act_a.new_status),
    .epc_we_o(act_a.epc_we), .epc_idx_o(act_a.epc_idx), .epc_data_o(act_a.epc_data),
    .eps_we_o(act_a.eps_we), .eps_idx_o(act_a.eps_idx), .eps_data_o(act_a.eps_data),
    .depc_we_o(act_a.depc_we), .depc_data_o(act_a.depc_data), .cause_we_o(act_a.cause_we),
    .cause_o(act_a.cause), .exc_class_o(act_a.exc_class));

  irq_entry_unit #(.NLEVEL(NL), .NIRQ(NI), .XLEN(XL), .HAS_DEPC(1'b0), .RELOC(1'b0), .DEF_VECBASE(DVB)) dut_nd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level), .status(status),
    .intset(intset), .intenable(intenable), .level_mask(level_mask), .cur_pc(cur_pc),
    .vecbase(vecbase), .vec_table(vec_table),
    .taken_o(act_b.taken), .new_pc_o(act_b.new_pc), .new_status_o(act_b.new_status),
    .epc_we_o(act_b.epc_we), .epc_idx_o(act_b.epc_idx), .epc_data_o(act_b.epc_data),
    .eps_we_o(act_b.eps_we), .eps_idx_o(act_b.eps_idx), .eps_data_o(act_b.eps_data),
    .depc_we_o(act_b.depc_we), .depc_data_o(act_b.depc_data), .cause_we_o(act_b.cause_we),
    .cause_o(act_b.cause), .exc_class_o(act_b.exc_class));

  function automatic logic [NI-1:0] mask_of(input logic [3:0] l);
    if (l == 0 || l > NL) return '0;
    return level_mask[(int'(l)-1)*NI +: NI];
  endfunction

  function automatic logic [31:0] vec_of(input logic [3:0] l);
    if (l == 0 || l > NL) return '0;
    return vec_table[(int'(l)-1)*XL +: XL];
  endfunction

  function automatic bit will_take();
    return req_valid && req_level != 0 && req_level <= NL && req_level > status[3:0]
        && ((mask_of(req_level) & intset & intenable) != 0);
  endfunction

  function automatic outs_t model(input outs_t p, input bit has_depc, input bit reloc);
    outs_t n = p;
    n.taken = 1'b0; n.epc_we = 1'b0; n.eps_we = 1'b0; n.depc_we = 1'b0;
    n.cause_we = 1'b0; n.exc_class = 2'd0;
    if (will_take()) begin
      n.taken = 1'b1;
      if (req_level > 1) begin
        n.new_pc = reloc ? (vec_of(req_level) - DVB + vecbase) : vec_of(req_level);
        n.new_status = {status[31:5], 1'b1, req_level};
        n.epc_we = 1'b1; n.epc_idx = req_level; n.epc_data = cur_pc;
        n.eps_we = 1'b1; n.eps_idx = req_level; n.eps_data = status;
      end else begin
        n.new_pc = cur_pc;
        n.new_status = status | 32'h10;
        n.cause_we = 1'b1; n.cause = 6'd4;
        if (status[4]) begin
          n.exc_class = 2'd3;
          if (has_depc) begin n.depc_we = 1'b1; n.depc_data = cur_pc; end
          else begin n.epc_we = 1'b1; n.epc_idx = 4'd1; n.epc_data = cur_pc; end
        end else begin
          n.exc_class = status[5] ? 2'd2 : 2'd1;
          n.epc_we = 1'b1; n.epc_idx = 4'd1; n.epc_data = cur_pc;
        end
      end
    end
    return n;
  endfunction

  function automatic string tag_for(input outs_t e);
    if (!e.taken) return "R1/R9";
    if (e.eps_we) return "R2/R3/R4";
    if (e.exc_class == 2'd3) return "R6";
    return "R7";
  endfunction

  task automatic compare(input string tag, input string which, input outs_t a, input outs_t e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, which, a, e);
    end
  endtask

  task automatic step_check();
    outs_t na, nb;
    na = model(exp_a, 1'b1, 1'b1);
    nb = model(exp_b, 1'b0, 1'b0);
    @(negedge clk);
    exp_a = na;
    exp_b = nb;
    compare(tag_for(exp_a), "dut", act_a, exp_a);
    compare(tag_for(exp_b), "dut_nd", act_b, exp_b);
  endtask

  task automatic fill_tables();
    for (int i = 0; i < NL; i++) begin
      level_mask[i*NI +: NI] = $urandom & $urandom;
      vec_table[i*XL +: XL] = DVB + 32'(i * 64) + 32'h180;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    exp_a = '0;
    exp_b = '0;
    fill_tables();
    vecbase = 32'h8000_0000;
    repeat (3) @(negedge clk);
    // R10 reset state
    compare("R10", "dut", act_a, '0);
    compare("R10", "dut_nd", act_b, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 level 6 with relocation, all lines enabled
    req_valid = 1; req_level = 4'd6; status = 32'h0000_0022; intset = '1; intenable = '1;
    level_mask[5*NI +: NI] = 32'h1; cur_pc = 32'h1234_5678; vecbase = 32'h9000_0000;
    step_check();
    // R9 outputs hold when request removed
    req_valid = 0;
    step_check();
    // R1 level equal to current level not taken
    req_valid = 1; req_level = 4'd3; status = 32'h3; level_mask[2*NI +: NI] = '1;
    step_check();
    // R1 level above NLEVEL not taken
    req_level = 4'd7; status = 32'h0;
    step_check();
    // R1 zero mask AND not taken
    req_level = 4'd2; level_mask[1*NI +: NI] = '0;
    step_check();
    // R6 level 1 double exception
    req_level = 4'd1; status = 32'h0000_0030; level_mask[0 +: NI] = 32'h8000_0000;
    cur_pc = 32'hCAFE_0010;
    step_check();
    // R7 level 1 user
    status = 32'h0000_0020; cur_pc = 32'hCAFE_0020;
    step_check();
    // R7 R8 level 1 kernel
    status = 32'hF000_0000; cur_pc = 32'hCAFE_0030;
    step_check();
    // R5 level 1 blocked by current level 1
    status = 32'h1;
    step_check();

    fill_tables();
    for (int k = 0; k < 400; k++) begin
      req_valid = ($urandom_range(0, 7) != 0);
      req_level = 4'($urandom_range(0, 7));
      status = $urandom;
      status[3:0] = 4'($urandom_range(0, 6));
      intset = $urandom;
      intenable = ($urandom_range(0, 3) == 0) ? '0 : 32'($urandom);
      cur_pc = $urandom;
      vecbase = $urandom;
      if ((k % 50) == 0) fill_tables();
      step_check();
    end

    req_valid = 0;
    step_check();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule